// File: doc/BRIEF.md
# Binary Reference Cross-Correlator

This block correlates a stream of 8-bit samples against a stream of one-bit reference symbols. Each accepted sample enters a tap delay line together with its reference bit, and the two lines always move in step. The sample code is offset-binary: code 128 means zero, 0 means -128 and 255 means +127. The reference bit weights its tap by +1 when set and by -1 when clear. Every tap's weighted value is added into one signed correlation value.

After each accepted sample, the block registers one correlation result. It flags the result as valid once the delay line holds a full window of samples. A typical use is matching a received sample stream against a known binary code, such as a preamble or a spreading sequence. A downstream stage then looks for peaks in the results.

Top module: `bin_ref_correlator`

## Requirements
- R1: While `rst_n` is low, `corr_valid` reads 0 and `corr_out` reads 0. After reset the delay lines are empty and the fill count is zero.
- R2: `corr_valid` stays low until TAPS samples have been accepted since the last reset. The first pulse belongs to the TAPS-th accepted sample.
- R3: A result is valid when `corr_valid` is high. Its value is the sum over the last TAPS accepted samples of w*(code-128). Here w is +1 if that sample's reference bit was 1 and -1 if it was 0. The result is a two's-complement value of ACC_W bits.
- R4: A sample accepted at clock edge E produces its result at edge E+1. `corr_valid` is high for exactly one cycle per accepted sample, so back-to-back samples give back-to-back results.
- R5: Cycles with `in_valid` low do not shift either delay line. They also do not change `corr_out` and do not raise `corr_valid`.
- R6: ACC_W = SW + clog2(TAPS) + 1. This width holds every possible sum without wrapping. With the defaults, all taps at code 0 with reference 0 give +1024, and all taps at code 0 with reference 1 give -1024.
- R7: A reset in the middle of a stream discards the window. After reset, a fresh TAPS samples are needed before `corr_valid` rises again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Accept `in_sample` and `in_ref` at this edge |
| in_sample | input | SW (8) | Sample in offset-binary code |
| in_ref | input | 1 | Reference symbol: 1 weights +1, 0 weights -1 |
| corr_valid | output | 1 | One-cycle strobe marking a valid correlation result |
| corr_out | output | ACC_W (12) | Signed correlation sum |

## Verification
Each fault has a distinct signature at the ports:
- A bias that is removed wrongly makes every result wrong by a multiple of 128 per tap. The all-128 window, which must give zero, exposes this on its first valid result.
- A swapped sign on the weighting flips the result of the all-zero-code windows between +1024 and -1024.
- A delay line that shifts while `in_valid` is low shows up on the next accepted sample. That sample's result then differs from a window that skipped the idle cycles.
- A fill counter that is off by one moves the first `corr_valid` pulse by one sample. This is visible right after reset.

// File: rtl/bin_ref_correlator.sv
module bin_ref_correlator #(
  parameter int TAPS = 8,
  parameter int SW = 8,
  localparam int ACC_W = SW + $clog2(TAPS) + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [SW-1:0]           in_sample,
  input  logic                    in_ref,
  output logic                    corr_valid,
  output logic signed [ACC_W-1:0] corr_out
);
  localparam int FILL_W = $clog2(TAPS + 1);

  logic [TAPS*SW-1:0]      smp_sr;
  logic [TAPS-1:0]         ref_sr;
  logic [FILL_W-1:0]       fill;
  logic                    fired;
  logic signed [ACC_W-1:0] prod [TAPS];
  logic signed [ACC_W-1:0] total;
  logic                    full;

  assign full = (fill == FILL_W'(TAPS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_sr <= '0;
      ref_sr <= '0;
      fill   <= '0;
    end else if (in_valid) begin
      smp_sr <= {smp_sr[(TAPS-1)*SW-1:0], in_sample};
      ref_sr <= {ref_sr[TAPS-2:0], in_ref};
      if (!full) fill <= fill + 1'b1;
    end
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_tap
    logic [SW-1:0]           raw;
    logic signed [SW-1:0]    ctr;
    logic signed [ACC_W-1:0] ext;
    assign raw     = smp_sr[k*SW +: SW];
    assign ctr     = {~raw[SW-1], raw[SW-2:0]};
    assign ext     = ACC_W'(ctr);
    assign prod[k] = ref_sr[k] ? ext : -ext;
  end

  always_comb begin
    total = '0;
    for (int k = 0; k < TAPS; k++) total = total + prod[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fired      <= 1'b0;
      corr_valid <= 1'b0;
      corr_out   <= '0;
    end else begin
      fired      <= in_valid;
      corr_valid <= fired && full;
      if (fired) corr_out <= total;
    end
  end
endmodule

module bin_ref_correlator_chk #(
  parameter int TAPS = 8,
  parameter int SW = 8,
  localparam int ACC_W = SW + $clog2(TAPS) + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    corr_valid,
  input logic signed [ACC_W-1:0] corr_out
);
  localparam int LIM = TAPS * (2 ** (SW - 1));
  int seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 0;
    else if (in_valid && seen < TAPS) seen <= seen + 1;
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!corr_valid && corr_out == '0));

  a_r2_window_full: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |-> seen >= TAPS);

  a_r4_one_edge_latency: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |-> $past(in_valid, 2));

  a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid, 2) |-> ($stable(corr_out) && !corr_valid));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    corr_valid |-> (int'(corr_out) <= LIM && int'(corr_out) >= -LIM));
endmodule

bind bin_ref_correlator bin_ref_correlator_chk #(.TAPS(TAPS), .SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
  .corr_valid(corr_valid), .corr_out(corr_out)
);

// File: tb/bin_ref_correlator_test.sv
module bin_ref_correlator_test;
  localparam int TAPS = 8;
  localparam int SW = 8;
  localparam int ACC_W = SW + $clog2(TAPS) + 1;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [SW-1:0] in_sample = '0;
  logic in_ref = 1'b0;
  logic corr_valid;
  logic signed [ACC_W-1:0] corr_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int m_s [TAPS];
  bit m_r [TAPS];
  int m_cnt = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bin_ref_correlator #(.TAPS(TAPS), .SW(SW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .in_ref(in_ref), .corr_valid(corr_valid), .corr_out(corr_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < TAPS; k++) begin m_s[k] = 128; m_r[k] = 1'b0; end
    m_cnt = 0;
  endtask

  task automatic model_push(input int s, input bit r);
    for (int k = TAPS - 1; k > 0; k--) begin m_s[k] = m_s[k-1]; m_r[k] = m_r[k-1]; end
    m_s[0] = s;
    m_r[0] = r;
    if (m_cnt < TAPS) m_cnt++;
  endtask

  function automatic int model_sum();
    int acc = 0;
    for (int k = 0; k < TAPS; k++) acc += m_r[k] ? (m_s[k] - 128) : (128 - m_s[k]);
    return acc;
  endfunction

  // isolated push: checks R4 latency and single-cycle pulse, R2 and R3 value
  task automatic push(input int s, input bit r);
    bit ev;
    @(negedge clk);
    in_valid = 1'b1; in_sample = SW'(s); in_ref = r;
    @(negedge clk);
    in_valid = 1'b0;
    model_push(s, r);
    ev = (m_cnt >= TAPS);
    chk(corr_valid == 1'b0, "R4 not before E+1", int'(corr_valid), 0);
    @(negedge clk);
    chk(corr_valid == ev, "R2 valid after full window", int'(corr_valid), int'(ev));
    if (ev) chk(int'(corr_out) == model_sum(), "R3 correlation value", int'(corr_out), model_sum());
    @(negedge clk);
    chk(corr_valid == 1'b0, "R4 single-cycle pulse", int'(corr_valid), 0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    model_reset();
    repeat (2) @(negedge clk);
    chk(corr_valid == 1'b0, "R1 valid low in reset", int'(corr_valid), 0);
    chk(corr_out == '0, "R1 output zero in reset", int'(corr_out), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_fill();
    for (int i = 0; i < TAPS; i++) push((37 * i + 11) % 256, (i % 3) != 0);
  endtask

  task automatic t_idle();
    int held;
    push(200, 1'b1);
    held = int'(corr_out);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk(corr_valid == 1'b0, "R5 no strobe while idle", int'(corr_valid), 0);
      chk(int'(corr_out) == held, "R5 output held while idle", int'(corr_out), held);
    end
    push(3, 1'b0);
  endtask

  task automatic t_stream();
    int eh [16];
    bit vh [16];
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk(corr_valid == vh[i-2], "R4 back-to-back strobe", int'(corr_valid), int'(vh[i-2]));
        if (vh[i-2]) chk(int'(corr_out) == eh[i-2], "R3 streamed value", int'(corr_out), eh[i-2]);
      end
      in_valid = 1'b1; in_sample = SW'((91 * i + 5) % 256); in_ref = (i % 2) == 0;
      model_push((91 * i + 5) % 256, (i % 2) == 0);
      vh[i] = (m_cnt >= TAPS);
      eh[i] = model_sum();
    end
    @(negedge clk);
    in_valid = 1'b0;
    chk(corr_valid == vh[10], "R4 back-to-back strobe", int'(corr_valid), int'(vh[10]));
    chk(int'(corr_out) == eh[10], "R3 streamed value", int'(corr_out), eh[10]);
    @(negedge clk);
    chk(corr_valid == vh[11], "R4 back-to-back strobe", int'(corr_valid), int'(vh[11]));
    chk(int'(corr_out) == eh[11], "R3 streamed value", int'(corr_out), eh[11]);
  endtask

  task automatic t_extremes();
    for (int i = 0; i < TAPS; i++) push(0, 1'b0);
    chk(int'(corr_out) == 1024, "R6 max positive", int'(corr_out), 1024);
    for (int i = 0; i < TAPS; i++) push(0, 1'b1);
    chk(int'(corr_out) == -1024, "R6 max negative", int'(corr_out), -1024);
    for (int i = 0; i < TAPS; i++) push(255, 1'b1);
    chk(int'(corr_out) == 1016, "R6 top code", int'(corr_out), 1016);
    for (int i = 0; i < TAPS; i++) push(128, 1'b0);
    chk(int'(corr_out) == 0, "R3 bias code gives zero", int'(corr_out), 0);
  endtask

  // R7: reset mid-stream needs a fresh full window
  task automatic t_midreset();
    push(17, 1'b1);
    do_reset();
    for (int i = 0; i < TAPS; i++) push(250 - 9 * i, (i % 2) == 1);
    chk(m_cnt == TAPS, "R7 window refilled", m_cnt, TAPS);
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    chk(corr_valid == 1'b0, "R1 valid low in reset", int'(corr_valid), 0);
    chk(corr_out == '0, "R1 output zero in reset", int'(corr_out), 0);
    rst_n = 1'b1;
    t_fill();
    t_idle();
    t_stream();
    t_extremes();
    t_midreset();
    repeat (2) @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule